// File: doc/BRIEF.md
# Peripheral Interrupt Flag Bank

This block holds the interrupt state of one peripheral. Each of up to 32 event inputs latches a sticky flag. A small register bus lets software read the flags, force flags high through a set register, drop them through a clear register, and choose which flags may raise the interrupt through an enable register. Every flag is masked by its enable bit, and the masked flags are OR-combined into one registered interrupt request line for the system interrupt controller.

A mode input selects atomic read-clear. When the mode is high, a read of the clear register returns the flag vector and, on the same clock edge, drops exactly the flags it returned. A service routine can therefore fetch and acknowledge its pending events in one bus access without losing an event that arrives in between. A hardware event always beats a software clear of the same flag in the same cycle.

Top module: `irq_flag_bank`

## Requirements
- R1: An event input high during a cycle sets the matching flag at the next rising clock edge.
- R2: A write to the set register (offset 1) sets every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R3: A write to the clear register (offset 2) clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: A write to the enable register (offset 3) replaces the whole enable vector, and a read of offset 3 returns it.
- R5: The request output is high exactly when some flag is high together with its enable bit, delayed by one clock edge after the flag and enable registers change.
- R6: With the read-clear mode input high, a read of the clear register returns the flag vector (flags read at offset 0), and the flags returned are zero after that clock edge.
- R7: With the read-clear mode input low, a read of the clear register leaves all flags unchanged; its returned value is not defined.
- R8: When an event and a clear (by write or by read-clear) hit the same flag in the same cycle, the flag ends set.
- R9: The flag register (offset 0) is read only; a write to it changes no flag.
- R10: After synchronous reset the flags, the enable vector and the request output are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 32 | Hardware event lines, one per flag |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register offset: 0 flags, 1 set, 2 clear, 3 enable |
| bus_wdata_i | input | 32 | Write data, always a full word |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| rdclr_mode_i | input | 1 | Read-clear mode for the clear register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that at most one bus access happens per cycle, that every write carries a full word, and that the read-clear mode input is steady around a read of the clear register. The no-side-effect check on a plain clear read also assumes the event lines are quiet in that cycle. The stimulus changes inputs only a short delay after a rising edge, issues one access per task call, and toggles the mode only between accesses. Events are driven alongside clears only in the cycles that deliberately test the collision rule.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int IRQF_ADDR_W = 2;

    typedef enum logic [IRQF_ADDR_W-1:0] {
        REG_FLAG = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_ENA  = 2'd3
    } irqf_reg_e;

    typedef struct packed {
        logic set_wr;
        logic clr_wr;
        logic ena_wr;
        logic rc_rd;
        logic plain_clr_rd;
    } irqf_strobe_t;

endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
    import irqf_pkg::*;
(
    input  logic                   sel_i,
    input  logic                   wr_i,
    input  logic [IRQF_ADDR_W-1:0] addr_i,
    input  logic                   rc_mode_i,
    output irqf_strobe_t           strb_o
);
    irqf_reg_e reg_sel;

    always_comb begin
        reg_sel              = irqf_reg_e'(addr_i);
        strb_o               = '0;
        strb_o.set_wr        = sel_i && wr_i && (reg_sel == REG_SET);
        strb_o.clr_wr        = sel_i && wr_i && (reg_sel == REG_CLR);
        strb_o.ena_wr        = sel_i && wr_i && (reg_sel == REG_ENA);
        strb_o.rc_rd         = sel_i && !wr_i && (reg_sel == REG_CLR) && rc_mode_i;
        strb_o.plain_clr_rd  = sel_i && !wr_i && (reg_sel == REG_CLR) && !rc_mode_i;
    end
endmodule

// File: rtl/irqf_flag_store.sv
module irqf_flag_store
    import irqf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_evt_i,
    input  irqf_strobe_t strb_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] en_o
);
    logic [W-1:0] flags_q, en_q;
    logic [W-1:0] set_mask, clr_mask, flags_d;

    always_comb begin
        set_mask = strb_i.set_wr ? wdata_i : '0;
        if (strb_i.clr_wr)
            clr_mask = wdata_i;
        else if (strb_i.rc_rd)
            clr_mask = flags_q;
        else
            clr_mask = '0;
        // events are ORed last so they survive any clear in the same cycle
        flags_d = (flags_q & ~clr_mask) | set_mask | hw_evt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= flags_d;
            if (strb_i.ena_wr)
                en_q <= wdata_i;
        end
    end

    assign flags_o = flags_q;
    assign en_o    = en_q;

    // R1 R8
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt_i) |=> ((flags_q & $past(hw_evt_i)) == $past(hw_evt_i)));

    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb_i.set_wr |=> ((flags_q & $past(wdata_i)) == $past(wdata_i)));

    // R3
    clr_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb_i.clr_wr |=> ((flags_q & $past(wdata_i) & ~$past(hw_evt_i)) == '0));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        strb_i.rc_rd |=> ((flags_q & $past(flags_q) & ~$past(hw_evt_i)) == '0));

    // R4
    ena_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb_i.ena_wr |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/irqf_req_gen.sv
module irqf_req_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags_i & en_i);
    end

    assign irq_o = irq_q;

    // R5
    irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (irq_q == $past(|(flags_i & en_i))));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irqf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [W-1:0]           evt_i,
    input  logic                   bus_sel_i,
    input  logic                   bus_wr_i,
    input  logic [IRQF_ADDR_W-1:0] bus_addr_i,
    input  logic [W-1:0]           bus_wdata_i,
    output logic [W-1:0]           bus_rdata_o,
    input  logic                   rdclr_mode_i,
    output logic                   irq_o
);
    irqf_strobe_t strb;
    logic [W-1:0] flags, en;

    irqf_decode u_decode (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .rc_mode_i (rdclr_mode_i),
        .strb_o    (strb)
    );

    irqf_flag_store #(.W(W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .hw_evt_i (evt_i),
        .strb_i   (strb),
        .wdata_i  (bus_wdata_i),
        .flags_o  (flags),
        .en_o     (en)
    );

    irqf_req_gen #(.W(W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .en_i    (en),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            unique case (irqf_reg_e'(bus_addr_i))
                REG_FLAG: bus_rdata_o = flags;
                REG_CLR:  bus_rdata_o = rdclr_mode_i ? flags : '0;
                REG_ENA:  bus_rdata_o = en;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // R7
    plain_clr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.plain_clr_rd && (evt_i == '0)) |=> (flags == $past(flags)));

    // R9
    flag_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel_i && bus_wr_i && (bus_addr_i == REG_FLAG) && (evt_i == '0))
            |=> (flags == $past(flags)));
endmodule

// File: tb/irq_flag_bank_tb_top.sv
module irq_flag_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rcm = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_flag_bank dut_i (
        .clk (clk), .rst (rst), .evt_i (evt),
        .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata),
        .rdclr_mode_i (rcm), .irq_o (irq)
    );

    localparam int NV = 6;
    localparam logic [1:0]  V_ADDR [NV] = '{2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd2};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_00F0, 32'h0000_0030, 32'hFFFF_FFFF,
                                            32'h8000_0001, 32'h0001_0040, 32'hFFFF_FFFF};
    localparam logic [31:0] V_EVT  [NV] = '{32'h0, 32'h0, 32'h0001_0000,
                                            32'h0, 32'h0000_0040, 32'h0};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0000_00F0, 32'h0000_00C0, 32'h0001_00C0,
                                            32'h8001_00C1, 32'h8000_00C1, 32'h0};
    localparam string       V_REQ  [NV] = '{"R2", "R3", "R9", "R2", "R8", "R3"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
    endtask

    task automatic write(input logic [1:0] a, input logic [31:0] d, input logic [31:0] e);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; evt = e;
        @(posedge clk); #2;
        idle();
    endtask

    task automatic read(input logic [1:0] a, input logic [31:0] e, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a; evt = e;
        #1 d = rdata;
        @(posedge clk); #2;
        idle();
    endtask

    task automatic tick(input logic [31:0] e);
        evt = e;
        @(posedge clk); #2;
        evt = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R10 reset state
        read(2'd0, '0, d); check("R10 flags", d, 32'h0);
        read(2'd3, '0, d); check("R10 enable", d, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);

        // table walk: one access (plus events), then read flags
        for (int i = 0; i < NV; i++) begin
            write(V_ADDR[i], V_DATA[i], V_EVT[i]);
            read(2'd0, '0, d);
            check(V_REQ[i], d, V_EXP[i]);
        end

        // R4 enable write and readback
        write(2'd3, 32'h0000_0100, '0);
        read(2'd3, '0, d); check("R4 enable readback", d, 32'h0000_0100);

        // R1 event sets flag, R5 request one edge later
        tick(32'h0000_0100);
        read(2'd0, '0, d); check("R1 event flag", d, 32'h0000_0100);
        check("R5 irq raised", {31'h0, irq}, 32'h1);
        write(2'd2, 32'h0000_0100, '0);
        check("R5 irq lags clear", {31'h0, irq}, 32'h1);
        tick('0);
        check("R5 irq dropped", {31'h0, irq}, 32'h0);
        tick(32'h0000_0008);
        tick('0); tick('0);
        check("R5 masked flag no irq", {31'h0, irq}, 32'h0);

        // R7 plain clear read has no effect
        write(2'd1, 32'h0000_000F, '0);
        read(2'd2, '0, d);
        read(2'd0, '0, d); check("R7 flags kept", d, 32'h0000_000F);

        // R6 read-clear returns and clears
        rcm = 1'b1;
        read(2'd2, '0, d); check("R6 returned", d, 32'h0000_000F);
        read(2'd0, '0, d); check("R6 cleared", d, 32'h0);

        // R8 event during read-clear survives
        write(2'd1, 32'h0000_0003, '0);
        read(2'd2, 32'h0000_0002, d); check("R6 returned pre-event", d, 32'h0000_0003);
        read(2'd0, '0, d); check("R8 event kept", d, 32'h0000_0002);
        rcm = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule